// File: doc/BRIEF.md
# Overlapping Mealy Serial Pattern Detector

This block watches a serial bit stream, taking one bit per clock edge whenever its valid strobe is high, and raises a detect flag when the five most recently accepted bits are 1, 1, 0, 1, 1 in order of arrival. Matches may overlap. After a hit, the trailing "11" of that match already counts as the first two bits of the next one. A stream of 11011011 therefore gives two hits.

The detect flag is Mealy-style. It is formed combinationally from the registered state and the bit currently on the input. This means it is high during the same cycle in which the fifth bit is presented, before the clock edge that accepts that bit. The state is kept in a bank of D flip-flops using a minimal three-bit binary code, and it is also brought out as a port. Cycles in which the strobe is low are skipped entirely: the state holds and no hit is reported.

Top module: `pat_mealy_det`

## Requirements
- R1: While the synchronous reset is high at a clock edge, the state becomes idle (code 0). Detect is low during any cycle in which the state is idle.
- R2: Detect is high in a cycle exactly when the strobe is high and the four previously accepted bits followed by the present input bit form 1,1,0,1,1.
- R3: Overlapping matches are reported. The input 11011011, all accepted, gives detect on the fifth bit and again on the eighth bit.
- R4: When the strobe is low, detect is low and the state code does not change at the next edge, whatever the value of the data bit.
- R5: Detect is combinational. It rises in the cycle in which the completing bit is presented, before the edge that accepts that bit.
- R6: The state code on `state_code` is 0 for nothing matched, 1 for "1", 2 for "11", 3 for "110" and 4 for "1101". Codes 5 to 7 never appear after reset.
- R7: An accepted 1 in state 4 reports detect and moves the state to 2.
- R8: An accepted 1 in state 2 keeps the state at 2. An accepted 0 in state 3 returns the state to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | Strobe: bit_in is accepted at this edge |
| bit_in | input | 1 | Serial data bit |
| detect | output | 1 | Mealy hit flag for the present bit |
| state_code | output | STATE_W | Encoded present state (values per R6) |

## Verification
On every cycle, the bound checker enforces the following: detect is never high without the strobe or with a 0 input, the state code holds while the strobe is low, it stays within the five legal codes, and it moves to 2 after every hit. Only the bench scenarios can show whether the hits land on the right bits of a stream. This covers the overlapping case, the timing of detect within the cycle relative to the accepting edge, the specific return paths in R8, and agreement with a reference model of the recent bits over a long pseudo-random stream with gaps in the strobe.

// File: rtl/pat_det_pkg.sv
package pat_det_pkg;
   localparam int unsigned CORE_W = 3;

   typedef enum logic [CORE_W-1:0] {
      ST_IDLE = 3'd0,
      ST_1    = 3'd1,
      ST_11   = 3'd2,
      ST_110  = 3'd3,
      ST_1101 = 3'd4
   } det_state_e;
endpackage

// File: rtl/pat_det_next.sv
module pat_det_next
   import pat_det_pkg::*;
(
   input  logic [CORE_W-1:0] cur_st,
   input  logic              acc,
   input  logic              din,
   output logic [CORE_W-1:0] nxt_st
);
   det_state_e step_st;

   always_comb begin
      unique case (cur_st)
         ST_IDLE: step_st = din ? ST_1    : ST_IDLE;
         ST_1:    step_st = din ? ST_11   : ST_IDLE;
         ST_11:   step_st = din ? ST_11   : ST_110;
         ST_110:  step_st = din ? ST_1101 : ST_IDLE;
         ST_1101: step_st = din ? ST_11   : ST_IDLE;
         default: step_st = ST_IDLE;
      endcase
   end

   assign nxt_st = acc ? step_st : cur_st;
endmodule

// File: rtl/pat_det_dbank.sv
module pat_det_dbank #(
   parameter int unsigned  W       = 3,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   for (genvar i = 0; i < W; i++) begin : g_ff
      always_ff @(posedge clk) begin
         if (rst) q[i] <= RST_VAL[i];
         else     q[i] <= d[i];
      end
   end
endmodule

// File: rtl/pat_det_out.sv
module pat_det_out
   import pat_det_pkg::*;
(
   input  logic [CORE_W-1:0] cur_st,
   input  logic              acc,
   input  logic              din,
   output logic              hit
);
   assign hit = acc && din && (cur_st == ST_1101);
endmodule

// File: rtl/pat_mealy_det.sv
module pat_mealy_det
   import pat_det_pkg::*;
#(
   parameter int unsigned STATE_W = 3
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               bit_valid,
   input  logic               bit_in,
   output logic               detect,
   output logic [STATE_W-1:0] state_code
);
   localparam int unsigned PAD_W = (STATE_W > CORE_W) ? STATE_W - CORE_W : 1;

   if (STATE_W < CORE_W) begin : g_bad_w
      $error("pat_mealy_det: STATE_W must be at least %0d", CORE_W);
   end

   logic [CORE_W-1:0] cur_st;
   logic [CORE_W-1:0] nxt_st;

   pat_det_next u_next (
      .cur_st (cur_st),
      .acc    (bit_valid),
      .din    (bit_in),
      .nxt_st (nxt_st)
   );

   pat_det_dbank #(
      .W       (CORE_W),
      .RST_VAL (ST_IDLE)
   ) u_reg (
      .clk (clk),
      .rst (rst),
      .d   (nxt_st),
      .q   (cur_st)
   );

   pat_det_out u_out (
      .cur_st (cur_st),
      .acc    (bit_valid),
      .din    (bit_in),
      .hit    (detect)
   );

   if (STATE_W > CORE_W) begin : g_pad
      logic [PAD_W-1:0] zpad;
      assign zpad       = '0;
      assign state_code = {zpad, cur_st};
   end else begin : g_exact
      assign state_code = cur_st;
   end
endmodule

// File: rtl/pat_mealy_det_chk.sv
module pat_mealy_det_chk #(
   parameter int unsigned STATE_W = 3
) (
   input logic               clk,
   input logic               rst,
   input logic               bit_valid,
   input logic               bit_in,
   input logic               detect,
   input logic [STATE_W-1:0] state_code
);
   AST_DETECT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
      detect |-> bit_valid); // R4

   AST_HOLD_WHEN_IDLE_STROBE: assert property (@(posedge clk) disable iff (rst)
      !bit_valid |=> $stable(state_code)); // R4

   AST_DETECT_NEEDS_ONE: assert property (@(posedge clk) disable iff (rst)
      detect |-> bit_in); // R2

   AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (rst)
      state_code <= STATE_W'(4)); // R6

   AST_HIT_GOES_TO_11: assert property (@(posedge clk) disable iff (rst)
      detect |=> (state_code == STATE_W'(2))); // R7

   AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (rst)
      (state_code == '0) |-> !detect); // R1
endmodule

bind pat_mealy_det pat_mealy_det_chk #(.STATE_W(STATE_W)) chk_i (
   .clk        (clk),
   .rst        (rst),
   .bit_valid  (bit_valid),
   .bit_in     (bit_in),
   .detect     (detect),
   .state_code (state_code)
);

// File: tb/pat_mealy_det_tb_top.sv
module pat_mealy_det_tb_top;
   localparam int unsigned STATE_W = 3;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               bit_valid = 1'b0;
   logic               bit_in = 1'b0;
   logic               detect;
   logic [STATE_W-1:0] state_code;

   int   n_chk = 0;
   int   n_err = 0;
   logic [3:0] hist = '0;
   int   hits = 0;

   always #4 clk = ~clk;

   pat_mealy_det #(.STATE_W(STATE_W)) dut_i (
      .clk        (clk),
      .rst        (rst),
      .bit_valid  (bit_valid),
      .bit_in     (bit_in),
      .detect     (detect),
      .state_code (state_code)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; bit_valid = 1'b0; bit_in = 1'b0;
      @(posedge clk); @(posedge clk); #1;
      chk(state_code == 0, "R1 state after reset", int'(state_code), 0);
      chk(detect == 1'b0, "R1 detect after reset", int'(detect), 0);
      @(negedge clk);
      rst = 1'b0;
      hist = '0;
      hits = 0;
   endtask

   // drive one cycle; detect checked against the reference before the edge
   task automatic step(input bit v, input bit b, input string req);
      bit exp_det;
      @(negedge clk);
      bit_valid = v; bit_in = b;
      #1;
      exp_det = v && b && (hist == 4'b1101);
      chk(detect == exp_det, req, int'(detect), int'(exp_det));
      if (detect) hits++;
      @(posedge clk); #1;
      if (v) hist = {hist[2:0], b};
   endtask

   task automatic chk_state(input int exp, input string req);
      chk(int'(state_code) == exp, req, int'(state_code), exp);
   endtask

   task automatic t_single();
      int exp_st[5] = '{1, 2, 3, 4, 2};
      bit pat[5]    = '{1, 1, 0, 1, 1};
      do_reset();
      for (int i = 0; i < 5; i++) begin
         step(1'b1, pat[i], "R2 single match");
         chk_state(exp_st[i], (i == 4) ? "R7 state after hit" : "R6 state code walk");
      end
      chk(hits == 1, "R2 one hit", hits, 1);
   endtask

   task automatic t_overlap();
      bit pat[8] = '{1, 1, 0, 1, 1, 0, 1, 1};
      do_reset();
      for (int i = 0; i < 8; i++) step(1'b1, pat[i], "R3 overlap stream");
      chk(hits == 2, "R3 two hits", hits, 2);
   endtask

   task automatic t_gap();
      do_reset();
      step(1'b1, 1'b1, "R4 gap");
      step(1'b1, 1'b1, "R4 gap");
      step(1'b0, 1'b0, "R4 gap skipped 0");
      chk_state(2, "R4 state held");
      step(1'b1, 1'b0, "R4 gap");
      step(1'b1, 1'b1, "R4 gap");
      chk_state(4, "R6 state 1101");
      step(1'b0, 1'b1, "R4 no detect with strobe low");
      chk_state(4, "R4 state held at 4");
      // Mealy: completing bit raises detect before its edge
      @(negedge clk);
      bit_valid = 1'b1; bit_in = 1'b1;
      #1;
      chk(detect == 1'b1, "R5 detect before edge", int'(detect), 1);
      chk_state(4, "R5 state not yet moved");
      @(posedge clk); #1;
      hist = {hist[2:0], 1'b1};
      chk_state(2, "R7 state after hit");
   endtask

   task automatic t_paths();
      do_reset();
      step(1'b1, 1'b1, "R8 path");
      step(1'b1, 1'b1, "R8 path");
      step(1'b1, 1'b1, "R8 111");
      chk_state(2, "R8 1 in state 2 stays");
      step(1'b1, 1'b0, "R8 path");
      chk_state(3, "R6 state 110");
      step(1'b1, 1'b0, "R8 0 in state 3");
      chk_state(0, "R8 0 in state 3 to idle");
   endtask

   task automatic t_random();
      logic [15:0] lfsr = 16'hACE1;
      int          bad  = 0;
      do_reset();
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[3:2] != 2'b00, lfsr[0] | lfsr[5], "R2 random stream");
         if (state_code > 4) bad++;
      end
      chk(bad == 0, "R6 legal codes in random run", bad, 0);
      chk(hits > 0, "R2 random run produced hits", hits, 1);
   endtask

   initial begin : watchdog
      #(8 * 100000);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      t_single();
      t_overlap();
      t_gap();
      t_paths();
      t_random();
      do_reset();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule